// File: doc/BRIEF.md
# Cascaded Core Clock Ratio Divider

This block derives the processor core clock from an already selected source clock. It does so with a chain of programmable integer divider stages. Each stage holds a ratio field, and the stage divides by that ratio plus one. A stage further down the chain advances only when the stage before it ends one of its output periods. The overall divide factor is therefore the product of the per-stage factors. The whole chain runs on the source clock. Each stage's output is carried as a one-cycle period-end strobe plus a waveform level. The last stage's strobe and level are brought out as `core_tick` and `core_lvl`.

Software writes all ratio fields at once through a plain control port. It can read the current control word back. A separate status vector holds one busy bit per stage. A new ratio never cuts a period short: it is loaded only when the running output period ends. The stage's busy bit stays set from the write until the new ratio is in force and one whole period at that ratio has elapsed. Software polls the status vector before it relies on the new frequency. Control and status pins are plain signals. There is no data stream and so no valid/ready handshake.

Top module: `core_clk_divider`

## Requirements
- R1: After reset the control word reads 0, every busy bit is 0, and `core_tick` is 1 in every source cycle.
- R2: Once all busy bits are clear, `core_tick` pulses once every (r1+1)*(r2+1) source cycles. r1 is the first-stage ratio, and the second stage counts only first-stage period ends.
- R3: The control word places the first-stage ratio in bits [2:0] and the second-stage ratio in bits [5:3]. `ctrl_q` returns the last value written and holds while `ctrl_we` is 0.
- R4: Per core period, `core_lvl` is high for floor((r2+1)/2)*(r1+1) source cycles when r2>0. When r2=0 it is high for floor((r1+1)/2) cycles if r1>0, and it is always high if both ratios are 0. An odd factor therefore gives a low-biased duty.
- R5: A new ratio is loaded only at the end of the stage's running output period, so the period during which the write happens keeps its old length.
- R6: A write sets every busy bit in the cycle after it. A bit clears only after its stage has applied the new ratio and finished one full period with it. Starting from a first-stage ratio of 0, busy bit 0 stays high for exactly r1+2 sampled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock feeding the first stage |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 6 | Ratio fields to write |
| ctrl_q | output | 6 | Control word read-back |
| stat_busy | output | 2 | Per-stage busy (1 = ratio still settling) |
| core_tick | output | 1 | One-cycle strobe at each core period end |
| core_lvl | output | 1 | Core clock waveform level |

## Verification
The assertions assume that `ctrl_we` is a single-cycle strobe with stable data, and that reset is held across at least one clock edge. Under those assumptions busy can only fall at a period end. The bench drives every write for exactly one cycle, starting from a falling edge. It then waits for all busy bits to clear before it measures a period or a duty count. The no-short-period case is the one exception: there the write is placed deliberately mid-period.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  typedef enum logic [1:0] {
    TRK_IDLE   = 2'd0,
    TRK_PEND   = 2'd1,
    TRK_SETTLE = 2'd2
  } trk_state_e;
endpackage

// File: rtl/cdiv_ctrl_reg.sv
module cdiv_ctrl_reg #(
  parameter int RATIO_W    = 3,
  parameter int NUM_STAGES = 2,
  localparam int CTRL_W    = RATIO_W * NUM_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (we) q <= wdata;
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R3
endmodule

// File: rtl/cdiv_settle_track.sv
module cdiv_settle_track
  import cdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic boundary,
  output logic apply,
  output logic busy
);
  trk_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (load) st_d = TRK_PEND;
    else if (boundary) begin
      case (st_q)
        TRK_PEND:   st_d = TRK_SETTLE;
        TRK_SETTLE: st_d = TRK_IDLE;
        default:    st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= TRK_IDLE;
    else st_q <= st_d;
  end

  assign apply = (st_q == TRK_PEND) && boundary && !load;
  assign busy  = (st_q != TRK_IDLE);

  AST_WRITE_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy); // R6
  AST_BUSY_HOLDS_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !boundary) |=> busy); // R6
  AST_APPLY_NEEDS_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    apply |-> boundary); // R5
endmodule

// File: rtl/cdiv_stage.sv
module cdiv_stage #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_in,
  input  logic               lvl_in,
  input  logic               apply,
  input  logic [RATIO_W-1:0] new_ratio,
  output logic               boundary,
  output logic               lvl_out
);
  logic [RATIO_W-1:0] act_q;
  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W:0]   half;

  assign boundary = en_in && (cnt_q == act_q);
  assign half     = ({1'b0, act_q} + (RATIO_W+1)'(1)) >> 1;
  assign lvl_out  = (act_q == '0) ? lvl_in : ({1'b0, cnt_q} < half);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
      cnt_q <= '0;
    end else if (en_in) begin
      if (cnt_q == act_q) begin
        cnt_q <= '0;
        if (apply) act_q <= new_ratio;
      end else begin
        cnt_q <= cnt_q + RATIO_W'(1);
      end
    end
  end

  AST_RATIO_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(act_q)); // R5
  AST_CNT_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= act_q); // R2
endmodule

// File: rtl/core_clk_divider.sv
module core_clk_divider #(
  parameter int RATIO_W    = 3,
  parameter int NUM_STAGES = 2,
  localparam int CTRL_W    = RATIO_W * NUM_STAGES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctrl_we,
  input  logic [CTRL_W-1:0]     ctrl_wdata,
  output logic [CTRL_W-1:0]     ctrl_q,
  output logic [NUM_STAGES-1:0] stat_busy,
  output logic                  core_tick,
  output logic                  core_lvl
);
  logic [NUM_STAGES:0] en_chain;
  logic [NUM_STAGES:0] lvl_chain;

  assign en_chain[0]  = 1'b1;
  assign lvl_chain[0] = 1'b1;

  cdiv_ctrl_reg #(.RATIO_W(RATIO_W), .NUM_STAGES(NUM_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata), .q(ctrl_q)
  );

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    logic bnd;
    logic app;

    cdiv_settle_track u_trk (
      .clk(clk), .rst_n(rst_n), .load(ctrl_we), .boundary(bnd),
      .apply(app), .busy(stat_busy[i])
    );

    cdiv_stage #(.RATIO_W(RATIO_W)) u_div (
      .clk(clk), .rst_n(rst_n), .en_in(en_chain[i]), .lvl_in(lvl_chain[i]),
      .apply(app), .new_ratio(ctrl_q[i*RATIO_W +: RATIO_W]),
      .boundary(bnd), .lvl_out(lvl_chain[i+1])
    );

    assign en_chain[i+1] = bnd;
  end

  assign core_tick = en_chain[NUM_STAGES];
  assign core_lvl  = lvl_chain[NUM_STAGES];

  AST_CORE_FOLLOWS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    core_tick |-> en_chain[1]); // R2
endmodule

// File: tb/core_clk_divider_test.sv
module core_clk_divider_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [5:0] ctrl_wdata = '0;
  logic [5:0] ctrl_q;
  logic [1:0] stat_busy;
  logic       core_tick;
  logic       core_lvl;
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  core_clk_divider uut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_q(ctrl_q), .stat_busy(stat_busy), .core_tick(core_tick), .core_lvl(core_lvl)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_ratios(input int r1, input int r2);
    @(negedge clk);
    ctrl_wdata = {3'(r2), 3'(r1)};
    ctrl_we = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (stat_busy == 2'b00) break;
    end
  endtask

  task automatic wait_tick();
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (core_tick) break;
    end
  endtask

  // Called right after a tick was seen; returns gap and high count of the period.
  task automatic measure(output int gap, output int high);
    gap = 0; high = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      gap++;
      if (core_lvl) high++;
      if (core_tick) break;
    end
  endtask

  task automatic t_reset();
    int ticks = 0;
    check("R1 ctrl_q", int'(ctrl_q), 0);
    check("R1 busy", int'(stat_busy), 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (core_tick && core_lvl) ticks++;
    end
    check("R1 pass-through ticks", ticks, 4);
  endtask

  task automatic t_busy_from_zero(input int r1);
    int cnt = 0;
    write_ratios(r1, 0);
    // the sample at the falling edge inside write_ratios already shows busy
    if (stat_busy[0]) cnt++;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (!stat_busy[0]) break;
      cnt++;
    end
    check("R6 busy length", cnt, r1 + 2);
    wait_idle();
  endtask

  task automatic t_ratio(input int r1, input int r2);
    int gap, high, exp_high;
    write_ratios(r1, r2);
    check("R6 busy set after write", int'(stat_busy), 3);
    check("R3 readback", int'(ctrl_q), (r2 << 3) | r1);
    wait_idle();
    wait_tick();
    measure(gap, high);
    check("R2 period", gap, (r1 + 1) * (r2 + 1));
    if (r2 > 0) exp_high = ((r2 + 1) / 2) * (r1 + 1);
    else if (r1 > 0) exp_high = (r1 + 1) / 2;
    else exp_high = 1;
    check("R4 high cycles", high, exp_high);
  endtask

  task automatic t_no_runt();
    int gap, high;
    write_ratios(7, 0);
    wait_idle();
    wait_tick();
    repeat (2) @(negedge clk);
    ctrl_wdata = 6'd1;
    ctrl_we = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0;
    gap = 3;
    for (int k = 0; k < 100; k++) begin
      if (core_tick) break;
      @(negedge clk);
      gap++;
    end
    check("R5 old period kept", gap, 8);
    measure(gap, high);
    check("R5 new period", gap, 2);
    wait_idle();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_busy_from_zero(4);
        t_ratio(3, 0);
        t_ratio(2, 1);
        t_ratio(4, 2);
        t_ratio(2, 0);
        t_ratio(0, 3);
        t_ratio(7, 7);
        t_ratio(0, 0);
        t_no_runt();
      end
      begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule